// File: doc/BRIEF.md
# Photon Counting Pixel with Adaptive Dead Time

This block is the digital back end of one single-photon counting pixel. An exposure is opened and closed by frame markers. While a frame is open, every avalanche pulse that arrives when the detector is armed is taken as one photon. A saturating per-pixel counter tallies these photons. After each accepted photon, the re-arm enable is withdrawn for a hold-off (dead time) before the detector may fire again. A global gate, shared by every pixel of the array, also forces the re-arm enable low.

The hold-off length adapts within the frame. A four-entry table pairs ascending photon-count thresholds with dead-time lengths given in clock cycles. The entry in force is the highest one whose threshold the live count has reached. Entry 0 applies whenever no higher entry qualifies.

At frame end, the count is copied into a readout register and the counter clears in the same cycle. The readout leaves through a valid/ready stream. The table is written through a second valid/ready port, which accepts writes only while no frame is open.

Top module: `photon_tally_pixel`

## Requirements
- R1: After reset, `tbl_ready_o` is 1 and `rd_valid_o` is 0. `arm_en_o` equals `gate_i`. Table entry i holds threshold i*32 and dead time 2*i+1, so `dt_code_o` reads 1.
- R2: A cycle in which `aval_i`, `arm_en_o` and an open frame are all high is a detection. Each detection adds one to the pixel count.
- R3: After a detection made while `dt_code_o` is D, `arm_en_o` is low for exactly the next D cycles and high again on the cycle after them. Pulses during those cycles are not counted. A D of 0 gives no hold-off.
- R4: While `gate_i` is 0, `arm_en_o` is 0 and avalanche pulses are not counted.
- R5: An avalanche pulse while no frame is open is not counted and starts no hold-off.
- R6: The count saturates at 127 and does not wrap. `rd_sat_o` is 1 exactly when the read-out count is 127.
- R7: `dt_code_o` is the dead time of the highest table entry i ≥ 1 whose threshold is ≤ the live count, or of entry 0 if there is no such entry. It follows a detection by one cycle.
- R8: `frame_start_i` clears the live count, so `dt_code_o` returns to the entry-0 dead time on the next cycle.
- R9: On `frame_end_i`, the readout register takes the count including any detection in that same cycle, and the live count clears. When `frame_end_i` and `frame_start_i` are asserted together, the frame stays open and no photon is lost.
- R10: `rd_valid_o` rises one cycle after `frame_end_i` and holds `rd_count_o`/`rd_sat_o` stable until a cycle with `rd_ready_i` high. A later `frame_end_i` before that overwrites the data with the newer frame.
- R11: The table port accepts a write only in a cycle with `tbl_valid_i` and `tbl_ready_o` both high. `tbl_ready_o` is 1 only while no frame is open. Field `tbl_idx_i` selects the entry, `tbl_thresh_i` is its count threshold and `tbl_dt_i` its dead time in cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_i | input | 1 | Global detector enable, shared by the array |
| aval_i | input | 1 | Avalanche pulse from the detector interface |
| frame_start_i | input | 1 | Opens an exposure and clears the count |
| frame_end_i | input | 1 | Closes an exposure and captures the count |
| tbl_valid_i | input | 1 | Table write request |
| tbl_ready_o | output | 1 | Table write accepted (no frame open) |
| tbl_idx_i | input | 2 | Table entry to write |
| tbl_thresh_i | input | 7 | Count threshold of the entry |
| tbl_dt_i | input | 4 | Dead time of the entry, in cycles |
| arm_en_o | output | 1 | Detector re-arm enable |
| dt_code_o | output | 4 | Dead time currently selected |
| rd_valid_o | output | 1 | Readout data valid |
| rd_ready_i | input | 1 | Readout consumer ready |
| rd_count_o | output | 7 | Photon count of the last closed frame |
| rd_sat_o | output | 1 | Last closed frame saturated |

## Verification
All inputs are driven and all outputs sampled on the falling clock edge, between the edges that register them. A detection driven at one falling edge shows up at the next falling edge: `dt_code_o` already holds the new value and `arm_en_o` has dropped. The bench then counts the falling edges at which `arm_en_o` stays low and compares that count with the dead time its own table model predicts for the count before the photon. Readout values are checked at the first falling edge after a `frame_end_i` cycle. Table writes and frame-state changes are likewise checked one edge after they are driven.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
  localparam int unsigned PTP_CNT_W   = 7;
  localparam int unsigned PTP_DT_W    = 4;
  localparam int unsigned PTP_ENTRIES = 4;

  typedef enum logic {
    FR_CLOSED = 1'b0,
    FR_OPEN   = 1'b1
  } frame_state_e;
endpackage

// File: rtl/ptp_holdoff.sv
module ptp_holdoff #(
  parameter int unsigned DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gate_i,
  input  logic            load_i,
  input  logic [DT_W-1:0] len_i,
  output logic            arm_o
);
  logic [DT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load_i) begin
      remain_q <= len_i;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign arm_o = gate_i && (remain_q == '0);
endmodule

// File: rtl/ptp_tally.sv
module ptp_tally #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             clear_i,
  input  logic             close_i,
  input  logic             rd_ready_i,
  output logic [CNT_W-1:0] live_o,
  output logic             rd_valid_o,
  output logic [CNT_W-1:0] rd_count_o,
  output logic             rd_sat_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] bumped;

  assign bumped = (hit_i && (cnt_q != TOP)) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= bumped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_count_o <= '0;
      rd_sat_o   <= 1'b0;
    end else if (close_i) begin
      rd_valid_o <= 1'b1;
      rd_count_o <= bumped;
      rd_sat_o   <= (bumped == TOP);
    end else if (rd_ready_i) begin
      rd_valid_o <= 1'b0;
    end
  end

  assign live_o = cnt_q;
endmodule

// File: rtl/ptp_dt_table.sv
module ptp_dt_table #(
  parameter int unsigned CNT_W   = 7,
  parameter int unsigned DT_W    = 4,
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [CNT_W-1:0] wr_thr_i,
  input  logic [DT_W-1:0]  wr_dt_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [DT_W-1:0]  dt_o
);
  localparam int unsigned STEP = (2 ** CNT_W) / ENTRIES;

  logic [CNT_W-1:0] thr_q [ENTRIES];
  logic [DT_W-1:0]  dt_q  [ENTRIES];
  logic [IDX_W-1:0] sel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    localparam logic [CNT_W-1:0] THR_RST = CNT_W'(g * STEP);
    localparam logic [DT_W-1:0]  DT_RST  = DT_W'(2 * g + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_q[g] <= THR_RST;
        dt_q[g]  <= DT_RST;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        thr_q[g] <= wr_thr_i;
        dt_q[g]  <= wr_dt_i;
      end
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 1; i < ENTRIES; i++) begin
      if (count_i >= thr_q[i]) begin
        sel = IDX_W'(i);
      end
    end
  end

  assign dt_o = dt_q[sel];
endmodule

// File: rtl/photon_tally_pixel.sv
module photon_tally_pixel
  import ptp_pkg::*;
#(
  parameter int unsigned CNT_W   = PTP_CNT_W,
  parameter int unsigned DT_W    = PTP_DT_W,
  parameter int unsigned ENTRIES = PTP_ENTRIES,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_i,
  input  logic             aval_i,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  input  logic             tbl_valid_i,
  output logic             tbl_ready_o,
  input  logic [IDX_W-1:0] tbl_idx_i,
  input  logic [CNT_W-1:0] tbl_thresh_i,
  input  logic [DT_W-1:0]  tbl_dt_i,
  output logic             arm_en_o,
  output logic [DT_W-1:0]  dt_code_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [CNT_W-1:0] rd_count_o,
  output logic             rd_sat_o
);
  frame_state_e     state_q;
  logic             frame_open;
  logic             hit;
  logic [CNT_W-1:0] live_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_CLOSED;
    end else if (frame_start_i) begin
      state_q <= FR_OPEN;
    end else if (frame_end_i) begin
      state_q <= FR_CLOSED;
    end
  end

  assign frame_open  = (state_q == FR_OPEN);
  assign tbl_ready_o = !frame_open;
  assign hit         = aval_i && arm_en_o && frame_open;

  ptp_holdoff #(.DT_W(DT_W)) u_holdoff (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_i (gate_i),
    .load_i (hit),
    .len_i  (dt_code_o),
    .arm_o  (arm_en_o)
  );

  ptp_tally #(.CNT_W(CNT_W)) u_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit),
    .clear_i    (frame_start_i || frame_end_i),
    .close_i    (frame_end_i),
    .rd_ready_i (rd_ready_i),
    .live_o     (live_count),
    .rd_valid_o (rd_valid_o),
    .rd_count_o (rd_count_o),
    .rd_sat_o   (rd_sat_o)
  );

  ptp_dt_table #(.CNT_W(CNT_W), .DT_W(DT_W), .ENTRIES(ENTRIES)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (tbl_valid_i && tbl_ready_o),
    .wr_idx_i (tbl_idx_i),
    .wr_thr_i (tbl_thresh_i),
    .wr_dt_i  (tbl_dt_i),
    .count_i  (live_count),
    .dt_o     (dt_code_o)
  );
endmodule

// File: rtl/ptp_chk.sv
module ptp_chk #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned DT_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_i,
  input logic             frame_start_i,
  input logic             frame_end_i,
  input logic             tbl_ready_o,
  input logic             arm_en_o,
  input logic [DT_W-1:0]  dt_code_o,
  input logic             rd_valid_o,
  input logic             rd_ready_i,
  input logic [CNT_W-1:0] rd_count_o,
  input logic             rd_sat_o,
  input logic             hit,
  input logic             frame_open,
  input logic [CNT_W-1:0] live_count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R3
  holdoff_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && dt_code_o != '0) |=> !arm_en_o);

  // R4
  gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_i |-> !arm_en_o);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && live_count != TOP && !frame_start_i && !frame_end_i)
      |=> live_count == CNT_W'($past(live_count) + 1'b1));

  // R6
  sat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (rd_sat_o == (rd_count_o == TOP)));

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> live_count == '0);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i && !frame_end_i)
      |=> rd_valid_o && $stable(rd_count_o) && $stable(rd_sat_o));

  // R11
  tbl_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_open |-> !tbl_ready_o);
endmodule

bind photon_tally_pixel ptp_chk #(.CNT_W(CNT_W), .DT_W(DT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .gate_i        (gate_i),
  .frame_start_i (frame_start_i),
  .frame_end_i   (frame_end_i),
  .tbl_ready_o   (tbl_ready_o),
  .arm_en_o      (arm_en_o),
  .dt_code_o     (dt_code_o),
  .rd_valid_o    (rd_valid_o),
  .rd_ready_i    (rd_ready_i),
  .rd_count_o    (rd_count_o),
  .rd_sat_o      (rd_sat_o),
  .hit           (hit),
  .frame_open    (frame_open),
  .live_count    (live_count)
);

// File: tb/photon_tally_pixel_tb.sv
module photon_tally_pixel_tb;
  localparam int CLK_P = 10;
  localparam int MAXC  = 127;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate_i = 1'b1;
  logic       aval_i = 1'b0;
  logic       frame_start_i = 1'b0;
  logic       frame_end_i = 1'b0;
  logic       tbl_valid_i = 1'b0;
  logic       tbl_ready_o;
  logic [1:0] tbl_idx_i = '0;
  logic [6:0] tbl_thresh_i = '0;
  logic [3:0] tbl_dt_i = '0;
  logic       arm_en_o;
  logic [3:0] dt_code_o;
  logic       rd_valid_o;
  logic       rd_ready_i = 1'b0;
  logic [6:0] rd_count_o;
  logic       rd_sat_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  int m_thr[4];
  int m_dt[4];
  int m_cnt = 0;

  always #(CLK_P / 2) clk = ~clk;

  photon_tally_pixel u_dut (
    .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .aval_i(aval_i),
    .frame_start_i(frame_start_i), .frame_end_i(frame_end_i),
    .tbl_valid_i(tbl_valid_i), .tbl_ready_o(tbl_ready_o), .tbl_idx_i(tbl_idx_i),
    .tbl_thresh_i(tbl_thresh_i), .tbl_dt_i(tbl_dt_i), .arm_en_o(arm_en_o),
    .dt_code_o(dt_code_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
    .rd_count_o(rd_count_o), .rd_sat_o(rd_sat_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mdt(input int c);
    int s = 0;
    for (int i = 1; i < 4; i++) if (c >= m_thr[i]) s = i;
    return m_dt[s];
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_arm();
    int g = 0;
    while (!arm_en_o && g < 40) begin g++; step(); end
  endtask

  task automatic pulse();
    int d_exp;
    int lows = 0;
    wait_arm();
    d_exp = mdt(m_cnt);
    aval_i = 1'b1;
    step();
    aval_i = 1'b0;
    if (m_cnt < MAXC) m_cnt++;
    chk("R7 dt_code after photon", dt_code_o, mdt(m_cnt));
    while (!arm_en_o && lows < 40) begin lows++; step(); end
    chk("R3 hold-off length", lows, d_exp);
  endtask

  task automatic open_frame();
    frame_start_i = 1'b1;
    step();
    frame_start_i = 1'b0;
    m_cnt = 0;
    chk("R8 dt_code at frame start", dt_code_o, m_dt[0]);
  endtask

  task automatic take_readout();
    rd_ready_i = 1'b1;
    step();
    rd_ready_i = 1'b0;
    chk("R10 valid drops after ready", rd_valid_o, 0);
  endtask

  task automatic close_frame(input int exp);
    frame_end_i = 1'b1;
    step();
    frame_end_i = 1'b0;
    chk("R9 readout valid", rd_valid_o, 1);
    chk("R2 readout count", rd_count_o, exp);
    chk("R6 saturation flag", rd_sat_o, (exp == MAXC) ? 1 : 0);
    take_readout();
  endtask

  task automatic load(input int idx, input int thr, input int dt);
    tbl_valid_i = 1'b1;
    tbl_idx_i = 2'(idx);
    tbl_thresh_i = 7'(thr);
    tbl_dt_i = 4'(dt);
    step();
    tbl_valid_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int sweep[$] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 31, 63, 64, 65,
                     100, 126, 127, 128, 130};
    for (int i = 0; i < 4; i++) begin m_thr[i] = i * 32; m_dt[i] = 2 * i + 1; end
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 arm_en", arm_en_o, 1);
    chk("R1 rd_valid", rd_valid_o, 0);
    chk("R1 tbl_ready", tbl_ready_o, 1);
    chk("R1 dt_code", dt_code_o, 1);

    // R11 table writes while closed
    load(0, 0, 2);  load(1, 3, 0);  load(2, 10, 5);  load(3, 64, 3);
    m_thr = '{0, 3, 10, 64};
    m_dt  = '{2, 0, 5, 3};
    chk("R11 loaded entry 0", dt_code_o, 2);

    // R11 write refused while a frame is open
    open_frame();
    chk("R11 tbl_ready low in frame", tbl_ready_o, 0);
    load(1, 1, 7);
    pulse();
    pulse();
    close_frame(2);

    // R2 R6 R7 sweep of photon counts per frame
    foreach (sweep[k]) begin
      open_frame();
      for (int p = 0; p < sweep[k]; p++) pulse();
      close_frame((sweep[k] > MAXC) ? MAXC : sweep[k]);
    end

    // R4 gate low blocks detection
    open_frame();
    pulse();
    pulse();
    gate_i = 1'b0;
    step();
    chk("R4 arm_en with gate low", arm_en_o, 0);
    aval_i = 1'b1;
    step();
    step();
    aval_i = 1'b0;
    gate_i = 1'b1;
    step();
    close_frame(2);

    // R5 pulse with no frame open
    aval_i = 1'b1;
    step();
    aval_i = 1'b0;
    chk("R5 no hold-off outside frame", arm_en_o, 1);
    open_frame();
    close_frame(0);

    // R9 back-to-back frames, photon in the boundary cycle
    open_frame();
    for (int p = 0; p < 4; p++) pulse();
    wait_arm();
    aval_i = 1'b1;
    frame_end_i = 1'b1;
    frame_start_i = 1'b1;
    step();
    aval_i = 1'b0;
    frame_end_i = 1'b0;
    frame_start_i = 1'b0;
    m_cnt = 0;
    chk("R9 boundary photon kept", rd_count_o, 5);
    chk("R9 readout valid", rd_valid_o, 1);
    chk("R8 dt_code after restart", dt_code_o, m_dt[0]);
    chk("R11 frame still open", tbl_ready_o, 0);
    take_readout();
    pulse();
    pulse();
    close_frame(2);

    // R10 readout held, then overwritten
    open_frame();
    for (int p = 0; p < 3; p++) pulse();
    frame_end_i = 1'b1;
    step();
    frame_end_i = 1'b0;
    repeat (3) step();
    chk("R10 valid held", rd_valid_o, 1);
    chk("R10 count held", rd_count_o, 3);
    open_frame();
    pulse();
    frame_end_i = 1'b1;
    step();
    frame_end_i = 1'b0;
    chk("R10 overwrite by newer frame", rd_count_o, 1);
    take_readout();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule